// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine for a multicycle 32-bit processor that executes one instruction over several clock cycles. It reads the 6-bit opcode field of the instruction register. From it the block works out the order of steps for that instruction and drives the datapath's control strobes in each step. These strobes include PC and memory writes, the instruction register load, the multiplexer selects for register destination, write data, ALU operands and next PC, and the ALU operation class.

Each instruction starts with the same two steps. The first is a fetch that loads the instruction and advances the PC by four. The second is a decode step that reads the registers and computes a branch target ahead of time. After that, each instruction class follows its own short path and then returns to fetch.

The controller handles loads, stores, register-register arithmetic, branch-if-equal, immediate add, and two kinds of jump. The first jump only redirects the PC. The second (jump-and-link) also writes the already-advanced PC into register 31 through 3-way destination and write-data selects. Opcodes outside this set go back to fetch after decode and write nothing.

Top module: `mcCtrlFsm`

## Requirements
- R1: `rst` is synchronous and active high. While it is sampled high, the block enters the fetch step, and the fetch strobes are shown in the cycle after that edge. This holds even in the middle of an instruction.
- R2: Fetch step. It asserts pcWrite=1, memRead=1, irWrite=1 and aluSrcB=1 (the constant 4). All other fields are 0: addrSel=0 selects PC, aluSrcA=0 selects PC, aluOpClass=0 means add, and pcSrcSel=0 selects the ALU result.
- R3: The decode step always follows fetch. It drives aluSrcB=3 (the shifted sign-extended offset) and sets every other field to 0.
- R4: Opcode 100011 (load) takes 5 cycles. The address step drives aluSrcA=1 and aluSrcB=2 (the sign-extended immediate). The read step drives addrSel=1 and memRead=1. The write-back step drives regWrite=1 with regDstSel=0 (rt) and wbDataSel=1 (memory data).
- R5: Opcode 101011 (store) takes 4 cycles. It uses the same address step as the load, then a step with addrSel=1 and memWrite=1.
- R6: Opcode 000000 (register-register) takes 4 cycles. The execute step drives aluSrcA=1, aluSrcB=0 (register B) and aluOpClass=2 (decode the function field). The write-back step drives regWrite=1 with regDstSel=1 (rd) and wbDataSel=0 (ALU output register).
- R7: Opcode 001000 (immediate add) takes 4 cycles. The execute step drives aluSrcA=1, aluSrcB=2 and aluOpClass=0. The write-back step drives regWrite=1 with regDstSel=0 (rt) and wbDataSel=0.
- R8: Opcode 000100 (branch-if-equal) takes 3 cycles. Its last step drives pcWriteCond=1, aluSrcA=1, aluSrcB=0, aluOpClass=1 (subtract) and pcSrcSel=1 (the registered target).
- R9: Opcode 000010 (jump) takes 3 cycles. Its last step drives pcWrite=1 and pcSrcSel=2 (PC upper 4 bits concatenated with the instruction's bits 25..0 shifted left by 2). Everything else is 0.
- R10: Opcode 000011 (jump-and-link) takes 3 cycles along the same path as the jump. Its last step also drives regWrite=1 with regDstSel=2 (register 31) and wbDataSel=2 (the PC, which already holds PC+4).
- R11: Any other opcode returns to fetch right after decode, so the instruction takes 2 cycles and no step writes any state.
- R12: regWrite, memWrite, pcWrite and pcWriteCond are 0 in every step that the requirements above do not name. Select and class fields that are not listed for a step are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pcWrite | output | 1 | Unconditional PC load |
| pcWriteCond | output | 1 | PC load when the ALU zero flag is set |
| addrSel | output | 1 | Memory address: 0 = PC, 1 = ALU output register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register load |
| regDstSel | output | 2 | Destination register: 0 = rt, 1 = rd, 2 = 31 |
| wbDataSel | output | 2 | Write data: 0 = ALU output reg, 1 = memory data, 2 = PC |
| regWrite | output | 1 | Register file write |
| aluSrcA | output | 1 | ALU A: 0 = PC, 1 = register A |
| aluSrcB | output | 2 | ALU B: 0 = register B, 1 = 4, 2 = immediate, 3 = immediate shifted by 2 |
| aluOpClass | output | 2 | 0 = add, 1 = subtract, 2 = function-field decode |
| pcSrcSel | output | 2 | Next PC: 0 = ALU result, 1 = ALU output reg, 2 = jump target |

## Verification
The assertions assume that `opcode` comes from an instruction register. That register loads only at the end of fetch, so the field is stable from decode until the instruction finishes. They also assume that reset is sampled only at clock edges. The stimulus changes the opcode only during the fetch cycle, which is just before the decode edge that samples it. The bench sweeps all 64 opcode values in turn, so every illegal code is also checked to go back through fetch without a write. A reset is applied once in the middle of a load to check that the write-back step is abandoned.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;

  localparam int OP_W  = 6;
  localparam int SEL_W = 2;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_JLINK = 6'b000011;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;

  // select encodings
  localparam logic [SEL_W-1:0] DST_RT   = 2'd0;
  localparam logic [SEL_W-1:0] DST_RD   = 2'd1;
  localparam logic [SEL_W-1:0] DST_LINK = 2'd2;
  localparam logic [SEL_W-1:0] WB_ALU   = 2'd0;
  localparam logic [SEL_W-1:0] WB_MEM   = 2'd1;
  localparam logic [SEL_W-1:0] WB_PC    = 2'd2;
  localparam logic [SEL_W-1:0] SB_REG   = 2'd0;
  localparam logic [SEL_W-1:0] SB_FOUR  = 2'd1;
  localparam logic [SEL_W-1:0] SB_IMM   = 2'd2;
  localparam logic [SEL_W-1:0] SB_IMMSH = 2'd3;
  localparam logic [SEL_W-1:0] AO_ADD   = 2'd0;
  localparam logic [SEL_W-1:0] AO_SUB   = 2'd1;
  localparam logic [SEL_W-1:0] AO_FUNCT = 2'd2;
  localparam logic [SEL_W-1:0] PS_ALU   = 2'd0;
  localparam logic [SEL_W-1:0] PS_TGT   = 2'd1;
  localparam logic [SEL_W-1:0] PS_JUMP  = 2'd2;

  typedef enum logic [2:0] {
    K_RTYPE, K_LOAD, K_STORE, K_BEQ, K_JMP, K_JLINK, K_ADDI, K_OTHER
  } opKind_t;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MEMADDR, S_MEMRD, S_MEMWB, S_MEMWR,
    S_RTEXEC, S_RTWB, S_BRANCH, S_JUMP, S_ADDIEXEC, S_ADDIWB
  } ctrlState_t;

  typedef struct packed {
    logic             pcWrite;
    logic             pcWriteCond;
    logic             addrSel;
    logic             memRead;
    logic             memWrite;
    logic             irWrite;
    logic [SEL_W-1:0] regDstSel;
    logic [SEL_W-1:0] wbDataSel;
    logic             regWrite;
    logic             aluSrcA;
    logic [SEL_W-1:0] aluSrcB;
    logic [SEL_W-1:0] aluOpClass;
    logic [SEL_W-1:0] pcSrcSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/opClassifier.sv
module opClassifier
  import mcCtrlPkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output opKind_t         kind
);
  always_comb begin
    unique case (opcode)
      OPC_RTYPE: kind = K_RTYPE;
      OPC_LOAD:  kind = K_LOAD;
      OPC_STORE: kind = K_STORE;
      OPC_BEQ:   kind = K_BEQ;
      OPC_JMP:   kind = K_JMP;
      OPC_JLINK: kind = K_JLINK;
      OPC_ADDI:  kind = K_ADDI;
      default:   kind = K_OTHER;
    endcase
  end
endmodule

// File: rtl/stateSequencer.sv
module stateSequencer
  import mcCtrlPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opKind_t    kind,
  output ctrlState_t state,
  output logic       isLink
);
  ctrlState_t nextState;
  logic       isStore;

  always_comb begin
    nextState = S_FETCH;
    unique case (state)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        unique case (kind)
          K_LOAD, K_STORE: nextState = S_MEMADDR;
          K_RTYPE:         nextState = S_RTEXEC;
          K_BEQ:           nextState = S_BRANCH;
          K_JMP, K_JLINK:  nextState = S_JUMP;
          K_ADDI:          nextState = S_ADDIEXEC;
          default:         nextState = S_FETCH;
        endcase
      end
      S_MEMADDR:  nextState = isStore ? S_MEMWR : S_MEMRD;
      S_MEMRD:    nextState = S_MEMWB;
      S_RTEXEC:   nextState = S_RTWB;
      S_ADDIEXEC: nextState = S_ADDIWB;
      default:    nextState = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_FETCH;
      isLink  <= 1'b0;
      isStore <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_DECODE) begin
        isLink  <= (kind == K_JLINK);
        isStore <= (kind == K_STORE);
      end
    end
  end

  // decode always follows fetch (R3)
  assert_fetch_then_decode_R3: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_DECODE);

  // unknown opcodes go straight back to fetch (R11)
  assert_other_returns_R11: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && kind == K_OTHER) |=> state == S_FETCH);

  // load path reaches its read step after the address step (R4)
  assert_load_path_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && kind == K_LOAD) |=> ##1 state == S_MEMRD);
endmodule

// File: rtl/strobeDecoder.sv
module strobeDecoder
  import mcCtrlPkg::*;
(
  input  ctrlState_t   state,
  input  logic         isLink,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    unique case (state)
      S_FETCH: begin
        strobes.pcWrite = 1'b1;
        strobes.memRead = 1'b1;
        strobes.irWrite = 1'b1;
        strobes.aluSrcB = SB_FOUR;
        strobes.pcSrcSel = PS_ALU;
      end
      S_DECODE: strobes.aluSrcB = SB_IMMSH;
      S_MEMADDR, S_ADDIEXEC: begin
        strobes.aluSrcA    = 1'b1;
        strobes.aluSrcB    = SB_IMM;
        strobes.aluOpClass = AO_ADD;
      end
      S_MEMRD: begin
        strobes.addrSel = 1'b1;
        strobes.memRead = 1'b1;
      end
      S_MEMWB: begin
        strobes.regWrite  = 1'b1;
        strobes.regDstSel = DST_RT;
        strobes.wbDataSel = WB_MEM;
      end
      S_MEMWR: begin
        strobes.addrSel  = 1'b1;
        strobes.memWrite = 1'b1;
      end
      S_RTEXEC: begin
        strobes.aluSrcA    = 1'b1;
        strobes.aluSrcB    = SB_REG;
        strobes.aluOpClass = AO_FUNCT;
      end
      S_RTWB: begin
        strobes.regWrite  = 1'b1;
        strobes.regDstSel = DST_RD;
        strobes.wbDataSel = WB_ALU;
      end
      S_ADDIWB: begin
        strobes.regWrite  = 1'b1;
        strobes.regDstSel = DST_RT;
        strobes.wbDataSel = WB_ALU;
      end
      S_BRANCH: begin
        strobes.pcWriteCond = 1'b1;
        strobes.aluSrcA     = 1'b1;
        strobes.aluSrcB     = SB_REG;
        strobes.aluOpClass  = AO_SUB;
        strobes.pcSrcSel    = PS_TGT;
      end
      S_JUMP: begin
        strobes.pcWrite  = 1'b1;
        strobes.pcSrcSel = PS_JUMP;
        if (isLink) begin
          strobes.regWrite  = 1'b1;
          strobes.regDstSel = DST_LINK;
          strobes.wbDataSel = WB_PC;
        end
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/mcCtrlFsm.sv
module mcCtrlFsm
  import mcCtrlPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  output logic             pcWrite,
  output logic             pcWriteCond,
  output logic             addrSel,
  output logic             memRead,
  output logic             memWrite,
  output logic             irWrite,
  output logic [SEL_W-1:0] regDstSel,
  output logic [SEL_W-1:0] wbDataSel,
  output logic             regWrite,
  output logic             aluSrcA,
  output logic [SEL_W-1:0] aluSrcB,
  output logic [SEL_W-1:0] aluOpClass,
  output logic [SEL_W-1:0] pcSrcSel
);
  opKind_t      kind;
  ctrlState_t   state;
  logic         isLink;
  ctrlStrobes_t strobes;

  opClassifier u_classify (.opcode(opcode), .kind(kind));

  stateSequencer u_seq (
    .clk(clk), .rst(rst), .kind(kind), .state(state), .isLink(isLink)
  );

  strobeDecoder u_dec (.state(state), .isLink(isLink), .strobes(strobes));

  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign addrSel     = strobes.addrSel;
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign irWrite     = strobes.irWrite;
  assign regDstSel   = strobes.regDstSel;
  assign wbDataSel   = strobes.wbDataSel;
  assign regWrite    = strobes.regWrite;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign aluOpClass  = strobes.aluOpClass;
  assign pcSrcSel    = strobes.pcSrcSel;

  // a link write happens together with the jump itself (R10)
  assert_link_with_jump_R10: assert property (@(posedge clk) disable iff (rst)
    (regWrite && regDstSel == DST_LINK) |-> (pcWrite && pcSrcSel == PS_JUMP && wbDataSel == WB_PC));

  // a register write is the last step of an instruction (R12)
  assert_wb_ends_instr_R12: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> irWrite);

  // a memory write is the last step of a store (R5)
  assert_store_ends_instr_R5: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> irWrite);

  // memory is never read and written in one step (R12)
  assert_mem_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  // the fetch step advances the PC and never writes a register (R2)
  assert_fetch_alone_R2: assert property (@(posedge clk) disable iff (rst)
    irWrite |-> (pcWrite && pcSrcSel == PS_ALU && !regWrite && !memWrite));
endmodule

// File: tb/sim_mcCtrlFsm.sv
module sim_mcCtrlFsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic pcWrite, pcWriteCond, addrSel, memRead, memWrite, irWrite, regWrite, aluSrcA;
  logic [1:0] regDstSel, wbDataSel, aluSrcB, aluOpClass, pcSrcSel;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mcCtrlFsm u0 (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .addrSel(addrSel),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
    .regDstSel(regDstSel), .wbDataSel(wbDataSel), .regWrite(regWrite),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOpClass(aluOpClass), .pcSrcSel(pcSrcSel)
  );

  function automatic logic [17:0] mk(input logic pw, pwc, ad, mr, mw, ir,
                                     input logic [1:0] rd, wd, input logic rw, sa,
                                     input logic [1:0] sb, ao, ps);
    return {pw, pwc, ad, mr, mw, ir, rd, wd, rw, sa, sb, ao, ps};
  endfunction

  function automatic logic [17:0] observed();
    return {pcWrite, pcWriteCond, addrSel, memRead, memWrite, irWrite, regDstSel,
            wbDataSel, regWrite, aluSrcA, aluSrcB, aluOpClass, pcSrcSel};
  endfunction

  function automatic logic [17:0] fetchVec();
    return mk(1,0,0,1,0,1,2'd0,2'd0,0,0,2'd1,2'd0,2'd0);
  endfunction

  function automatic int expLen(input logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011, 6'b000000, 6'b001000: return 4;
      6'b000100, 6'b000010, 6'b000011: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string reqTag(input logic [5:0] op);
    case (op)
      6'b100011: return "R4";
      6'b101011: return "R5";
      6'b000000: return "R6";
      6'b001000: return "R7";
      6'b000100: return "R8";
      6'b000010: return "R9";
      6'b000011: return "R10";
      default:   return "R11";
    endcase
  endfunction

  function automatic logic [17:0] expVec(input logic [5:0] op, input int step);
    if (step == 0) return fetchVec();
    if (step == 1) return mk(0,0,0,0,0,0,2'd0,2'd0,0,0,2'd3,2'd0,2'd0);
    case (op)
      6'b100011: begin
        if (step == 2) return mk(0,0,0,0,0,0,2'd0,2'd0,0,1,2'd2,2'd0,2'd0);
        if (step == 3) return mk(0,0,1,1,0,0,2'd0,2'd0,0,0,2'd0,2'd0,2'd0);
        return mk(0,0,0,0,0,0,2'd0,2'd1,1,0,2'd0,2'd0,2'd0);
      end
      6'b101011: begin
        if (step == 2) return mk(0,0,0,0,0,0,2'd0,2'd0,0,1,2'd2,2'd0,2'd0);
        return mk(0,0,1,0,1,0,2'd0,2'd0,0,0,2'd0,2'd0,2'd0);
      end
      6'b000000: begin
        if (step == 2) return mk(0,0,0,0,0,0,2'd0,2'd0,0,1,2'd0,2'd2,2'd0);
        return mk(0,0,0,0,0,0,2'd1,2'd0,1,0,2'd0,2'd0,2'd0);
      end
      6'b001000: begin
        if (step == 2) return mk(0,0,0,0,0,0,2'd0,2'd0,0,1,2'd2,2'd0,2'd0);
        return mk(0,0,0,0,0,0,2'd0,2'd0,1,0,2'd0,2'd0,2'd0);
      end
      6'b000100: return mk(0,1,0,0,0,0,2'd0,2'd0,0,1,2'd0,2'd1,2'd1);
      6'b000010: return mk(1,0,0,0,0,0,2'd0,2'd0,0,0,2'd0,2'd0,2'd2);
      6'b000011: return mk(1,0,0,0,0,0,2'd2,2'd2,1,0,2'd0,2'd0,2'd2);
      default:   return fetchVec();
    endcase
  endfunction

  task automatic check(input string tag, input logic [17:0] exp);
    logic [17:0] got;
    got = observed();
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: control vector %b, expected %b", tag, got, exp);
    end
  endtask

  // entry and exit: at a falling edge while the fetch step is current
  task automatic runInstr(input logic [5:0] op);
    int len;
    len = expLen(op);
    check({reqTag(op), " R2 fetch"}, fetchVec());
    opcode = op;
    for (int step = 1; step < len; step++) begin
      @(negedge clk);
      check((step == 1) ? {reqTag(op), " R3 decode"} : {reqTag(op), " R12 step"},
            expVec(op, step));
    end
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", fetchVec());
    rst = 1'b0;
    for (int i = 0; i < 64; i++) runInstr(6'(i));
    // R1: reset in the middle of a load abandons it
    check("R1 pre-load fetch", fetchVec());
    opcode = 6'b100011;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-instruction", fetchVec());
    rst = 1'b0;
    runInstr(6'b000011);
    runInstr(6'b100011);
    runInstr(6'b101011);
    check("R2 final fetch", fetchVec());
    summary();
  end
endmodule